// File: doc/BRIEF.md
# Oversampled Camera Parallel Port Receiver

This block takes in an 8-bit camera pixel bus with its vertical and horizontal sync lines and its pixel clock. The pixel clock never clocks a register. It is treated as one more data line and sampled by the faster system clock, so the system clock must run at least twice as fast as the pixel clock. All eleven camera lines pass through the same two-flop synchroniser. A capture edge is found by comparing the synchronised pixel clock level with its level one system cycle earlier. One configuration bit chooses whether the rising or the falling transition is the capture edge.

On each capture edge the block registers the byte and both sync levels from the same synchronised sample. It emits a one-cycle valid strobe while horizontal sync is active. Separate one-cycle flags mark the first sample of a frame and the first sample of a line. The same system clock also feeds an even-ratio divider that drives the master clock sent back to the camera.

Top module: `cam_port_rx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the following cycle shows `pix_valid`, `frame_start`, `line_start` and `cam_mclk_out` all low. The stored sync history and pixel clock history are cleared to low.
- R2: With `cfg_capture_falling` = 0, a low-to-high change of `cam_pclk` is the capture edge. The `pix_data` that goes with it is the `cam_data` value present together with the new high level.
- R3: With `cfg_capture_falling` = 1, a high-to-low change of `cam_pclk` is the capture edge. The data value present together with the new low level is captured.
- R4: `pix_valid` is high for exactly one cycle per capture edge, and only if `cam_hsync` was high in the captured sample.
- R5: Input lines are driven between clock edges. Their levels are sampled at the next rising system clock edge k. The strobe and flags from a capture edge seen in that sample are visible after edge k+2.
- R6: `frame_start` pulses for one cycle on the first capture edge whose sample has `cam_vsync` high, after a capture with `cam_vsync` low or after reset.
- R7: `line_start` pulses together with `pix_valid` on the first capture edge whose sample has `cam_hsync` high, after a capture with `cam_hsync` low or after reset.
- R8: `cam_mclk_out` toggles every ratio/2 system cycles, which gives a 50% duty cycle. The first toggle, from low to high, follows the ratio/2-th rising edge after reset is released. A ratio of 2 gives a clock at half the system rate.
- R9: An odd `cfg_div_ratio` is rounded down to the next even value. A value below 2 acts as 2. For example, 7 behaves as 6, and 0, 1 and 3 behave as 2.
- R10: A pixel clock held at one level produces no strobe and no flag, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the camera master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_capture_falling | input | 1 | 0: capture on pixel clock rise; 1: capture on fall |
| cfg_div_ratio | input | DIV_W (8) | Master clock division ratio |
| cam_pclk | input | 1 | Camera pixel clock, sampled as data |
| cam_vsync | input | 1 | Camera vertical sync, active high |
| cam_hsync | input | 1 | Camera horizontal sync, active high |
| cam_data | input | DATA_W (8) | Camera pixel byte |
| cam_mclk_out | output | 1 | Divided master clock to the camera |
| pix_valid | output | 1 | One-cycle strobe for a captured pixel |
| pix_data | output | DATA_W (8) | Captured pixel byte |
| frame_start | output | 1 | First capture after vertical sync went active |
| line_start | output | 1 | First capture after horizontal sync went active |

## Verification
The assertions assume that the pixel clock holds each level for at least one full system cycle. Under that assumption two capture edges can never fall in adjacent cycles, so every strobe and flag is followed by a low cycle. They also assume that the division ratio changes only while reset is held. The stimulus drives every camera line on the falling system clock edge. It holds each pixel clock phase for one to four cycles, changes the ratio and capture polarity only inside reset, and keeps the pixel clock low through reset so that the first high level is a genuine edge.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;

  // Half period of the divided master clock, in system cycles.
  // Odd ratios round down to even; ratios below 2 act as 2.
  function automatic int unsigned mclk_half(input int unsigned ratio);
    int unsigned even_r;
    even_r = ratio & ~32'd1;
    if (even_r < 2) even_r = 2;
    return even_r >> 1;
  endfunction

  // Capture-edge selection from the current and previous pixel clock samples.
  function automatic logic pick_capture(input logic now_lvl,
                                        input logic was_lvl,
                                        input logic on_fall);
    logic up, down;
    up   = now_lvl & ~was_lvl;
    down = ~now_lvl & was_lvl;
    return on_fall ? down : up;
  endfunction

endpackage

// File: rtl/cam_in_sync.sv
module cam_in_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cam_edge_capture.sv
module cam_edge_capture
  import cam_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_on_fall,
  input  logic              s_pclk,
  input  logic              s_vsync,
  input  logic              s_hsync,
  input  logic [DATA_W-1:0] s_data,
  output logic              cap_evt,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              frame_start,
  output logic              line_start
);

  logic pclk_hist;
  logic vs_hist;
  logic hs_hist;

  assign cap_evt = pick_capture(s_pclk, pclk_hist, cfg_on_fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_hist   <= 1'b0;
      vs_hist     <= 1'b0;
      hs_hist     <= 1'b0;
      pix_valid   <= 1'b0;
      pix_data    <= '0;
      frame_start <= 1'b0;
      line_start  <= 1'b0;
    end else begin
      pclk_hist   <= s_pclk;
      pix_valid   <= cap_evt & s_hsync;
      frame_start <= cap_evt & s_vsync & ~vs_hist;
      line_start  <= cap_evt & s_hsync & ~hs_hist;
      if (cap_evt) begin
        pix_data <= s_data;
        vs_hist  <= s_vsync;
        hs_hist  <= s_hsync;
      end
    end
  end

endmodule

// File: rtl/cam_clk_div.sv
module cam_clk_div
  import cam_rx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  output logic             mclk
);

  localparam int CNT_W = DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    int unsigned h;
    h       = mclk_half(32'(ratio));
    half_m1 = CNT_W'(h - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      mclk <= 1'b0;
    end else if (cnt >= half_m1) begin
      cnt  <= '0;
      mclk <= ~mclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cam_port_rx.sv
module cam_port_rx #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_capture_falling,
  input  logic [DIV_W-1:0]  cfg_div_ratio,
  input  logic              cam_pclk,
  input  logic              cam_vsync,
  input  logic              cam_hsync,
  input  logic [DATA_W-1:0] cam_data,
  output logic              cam_mclk_out,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              frame_start,
  output logic              line_start
);

  localparam int BUS_W  = DATA_W + 3;
  localparam int B_PCLK = DATA_W + 2;
  localparam int B_VS   = DATA_W + 1;
  localparam int B_HS   = DATA_W;

  logic [BUS_W-1:0] raw_bus;
  logic [BUS_W-1:0] syn_bus;
  logic             cap_evt;

  assign raw_bus = {cam_pclk, cam_vsync, cam_hsync, cam_data};

  cam_in_sync #(
    .W      (BUS_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (syn_bus)
  );

  cam_edge_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_on_fall (cfg_capture_falling),
    .s_pclk      (syn_bus[B_PCLK]),
    .s_vsync     (syn_bus[B_VS]),
    .s_hsync     (syn_bus[B_HS]),
    .s_data      (syn_bus[DATA_W-1:0]),
    .cap_evt     (cap_evt),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .frame_start (frame_start),
    .line_start  (line_start)
  );

  cam_clk_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .ratio (cfg_div_ratio),
    .mclk  (cam_mclk_out)
  );

endmodule

// File: rtl/cam_port_rx_chk.sv
module cam_port_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic cap_evt,
  input logic pix_valid,
  input logic frame_start,
  input logic line_start,
  input logic cam_mclk_out
);

  // R1: reset clears strobes, flags and the master clock
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!pix_valid && !frame_start && !line_start && !cam_mclk_out));

  // R4: a strobe lasts one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  // R4: a strobe is always preceded by a detected capture edge
  a_r4_valid_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(cap_evt));

  // R6: frame flag lasts one cycle
  a_r6_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R7: line flag only with a valid pixel
  a_r7_line_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_valid);

endmodule

bind cam_port_rx cam_port_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_evt      (cap_evt),
  .pix_valid    (pix_valid),
  .frame_start  (frame_start),
  .line_start   (line_start),
  .cam_mclk_out (cam_mclk_out)
);

// File: tb/sim_cam_port_rx.sv
module sim_cam_port_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fall = 1'b0;
  logic [7:0] cfg_ratio = 8'd2;
  logic       pclk = 1'b0;
  logic       vs = 1'b0;
  logic       hs = 1'b0;
  logic [7:0] dat = 8'd0;
  logic       mclk, pv, fs, ls;
  logic [7:0] pd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cam_port_rx u0 (
    .clk (clk), .rst_n (rst_n), .cfg_capture_falling (cfg_fall),
    .cfg_div_ratio (cfg_ratio), .cam_pclk (pclk), .cam_vsync (vs),
    .cam_hsync (hs), .cam_data (dat), .cam_mclk_out (mclk),
    .pix_valid (pv), .pix_data (pd), .frame_start (fs), .line_start (ls)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [10:0] hist[$];
  bit   e_pv, e_fs, e_ls, e_mclk, seen_vs, seen_hs;
  int   e_pd, mcount;

  function automatic int half_of(input int r);
    int eff;
    eff = (r < 2) ? 2 : r - (r % 2);
    return eff / 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{11'd0, 11'd0, 11'd0};
      e_pv = 0; e_fs = 0; e_ls = 0; e_mclk = 0;
      seen_vs = 0; seen_hs = 0; mcount = 0;
    end else begin
      logic [10:0] cur, old;
      bit hit;
      cur = hist[hist.size()-2];
      old = hist[hist.size()-3];
      hit = cfg_fall ? (old[10] && !cur[10]) : (!old[10] && cur[10]);
      e_pv = hit && cur[8];
      e_fs = hit && cur[9] && !seen_vs;
      e_ls = hit && cur[8] && !seen_hs;
      if (hit) begin
        e_pd = int'(cur[7:0]);
        seen_vs = cur[9];
        seen_hs = cur[8];
      end
      mcount++;
      if (mcount == half_of(int'(cfg_ratio))) begin
        e_mclk = !e_mclk;
        mcount = 0;
      end
      hist.push_back({pclk, vs, hs, dat});
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(pv == e_pv, "R4", "pix_valid", pv, e_pv);
      if (e_pv) check(pd == e_pd[7:0], cfg_fall ? "R3" : "R2", "pix_data", pd, e_pd);
      check(fs == e_fs, "R6", "frame_start", fs, e_fs);
      check(ls == e_ls, "R7", "line_start", ls, e_ls);
      check(mclk == e_mclk, "R8", "cam_mclk_out", mclk, e_mclk);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pixel(input logic [7:0] v, input int lo, input int hi);
    @(negedge clk); dat = v; pclk = 1'b0; wait_n(lo - 1);
    @(negedge clk); pclk = 1'b1; wait_n(hi - 1);
  endtask

  task automatic frame(input int lines, input int pix, input int lo, input int hi, input int seed);
    @(negedge clk); vs = 1'b1;
    for (int l = 0; l < lines; l++) begin
      hs = 1'b1;
      for (int p = 0; p < pix; p++) pixel(8'((seed + l * 37 + p * 11) & 8'hff), lo, hi);
      hs = 1'b0;
      for (int g = 0; g < 2; g++) pixel(8'hEE, lo, hi);
    end
    vs = 1'b0;
    for (int g = 0; g < 3; g++) pixel(8'h11, lo, hi);
  endtask

  task automatic do_reset(input logic fall, input logic [7:0] ratio);
    @(negedge clk); rst_n = 1'b0; pclk = 1'b0; vs = 1'b0; hs = 1'b0;
    cfg_fall = fall; cfg_ratio = ratio;
    wait_n(3);
    check(!pv && !fs && !ls && !mclk, "R1", "outputs in reset", {pv, fs, ls, mclk}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int hcount, vcount;
    do_reset(1'b0, 8'd2);

    // R5: latency of a single rising capture, with frame and line flags
    @(negedge clk); vs = 1'b1; hs = 1'b1; dat = 8'hA5; pclk = 1'b0;
    wait_n(2);
    @(negedge clk); pclk = 1'b1;
    @(negedge clk); check(pv == 1'b0, "R5", "valid one edge after", pv, 0);
    @(negedge clk); check(pv == 1'b0, "R5", "valid two edges after", pv, 0);
    @(negedge clk); check(pv == 1'b1 && pd == 8'hA5, "R5", "valid three edges after", pv, 1);
    check(fs && ls, "R6", "first flags with first pixel", {fs, ls}, 3);
    @(negedge clk); check(pv == 1'b0, "R4", "strobe one cycle", pv, 0);

    // R10: pixel clock held high, then low, gives no strobe
    vcount = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pv || fs || ls) vcount++; end
    check(vcount == 0, "R10", "strobes while level held high", vcount, 0);
    @(negedge clk); pclk = 1'b0; wait_n(4);
    vcount = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pv) vcount++; end
    check(vcount == 0, "R10", "strobes while level held low", vcount, 0);
    vs = 1'b0; hs = 1'b0;
    for (int g = 0; g < 2; g++) pixel(8'h00, 2, 2);

    // R2: rising capture, several phase lengths
    frame(3, 6, 2, 3, 5);
    frame(2, 5, 1, 1, 90);
    frame(2, 4, 4, 1, 200);

    // R3: falling capture, ratio 7 -> 6 (R9)
    do_reset(1'b1, 8'd7);
    hcount = 0;
    @(negedge clk); while (!mclk) @(negedge clk);
    while (mclk) begin hcount++; @(negedge clk); end
    check(hcount == 3, "R9", "high time for ratio 7", hcount, 3);
    frame(3, 5, 2, 2, 17);
    frame(2, 6, 1, 3, 140);

    // R9: ratios below two and odd small ratio
    do_reset(1'b0, 8'd0);
    frame(1, 4, 2, 2, 60);
    do_reset(1'b1, 8'd3);
    frame(2, 3, 3, 2, 33);
    do_reset(1'b0, 8'd10);
    frame(2, 5, 2, 2, 77);
    wait_n(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule